// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a VCO-rate clock for the feedback path of a PLL. It emits one single-cycle pulse at the end of each division cycle. The integer ratio is set by two fields, a coarse count `n_i` and a fine count `a_i`, and equals 2·n + a + 1. A fractional enable adds offset/64 to the average ratio. A 6-bit phase accumulator adds the offset once per output cycle, and each carry out of it stretches that cycle by one VCO clock. Over any 64 consecutive cycles the stretches add up to exactly the offset.

Configuration is captured only when a division cycle ends, so a write in the middle of a cycle cannot cut a cycle short. Two flags report on the captured setting. An error flag marks the unstable case: spread enabled, offset zero and fractional mode off. In that case the divider runs at the integer ratio. A warning flag marks fractional operation with a fine count too small for an accurate fraction. The spread-spectrum enable takes part only in error detection and never changes the period.

Top module: `frac_fb_div`

## Requirements
- R1: With `frac_en_i` low, every output period is exactly 2·n + a + 1 VCO cycles, and `offset_i` has no effect.
- R2: With `frac_en_i` high, each period is 2·n + a + 1 or one more, and any 64 consecutive periods total 64·(2·n + a + 1) + offset cycles.
- R3: n = 15, a = 2, offset = 48 in fractional mode gives 2160 cycles over 64 periods, an average of 33.75.
- R4: In fractional mode, toggling `ss_en_i` leaves the period totals unchanged.
- R5: `cfg_err_o` is high exactly when the captured setting has `ss_en_i` = 1, `frac_en_i` = 0 and `offset_i` = 0. The divider then runs at the integer ratio.
- R6: `frac_warn_o` is high exactly when the captured setting has `frac_en_i` = 1 and `a_i` ≤ 2.
- R7: Inputs are captured on the clock edge that ends a pulse cycle. A change made mid-cycle takes effect only from the next period, and the flags change only on those edges.
- R8: For a ratio of 2 or more, `div_o` is high for exactly one VCO cycle per period. For a ratio of 1 it is high every cycle.
- R9: While `rst_ni` is low, `div_o`, `cfg_err_o` and `frac_warn_o` are 0 and the accumulator is cleared. The first pulse after release is seen on the ratio-th cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | VCO-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_i | input | NW | Coarse count, weighs 2 in the ratio |
| a_i | input | 4 | Fine count, weighs 1 in the ratio |
| offset_i | input | 6 | Fractional offset in 1/64 steps |
| frac_en_i | input | 1 | Fractional divide enable |
| ss_en_i | input | 1 | Spread-spectrum enable, used for error detection |
| div_o | output | 1 | Divided pulse, one VCO cycle wide |
| cfg_err_o | output | 1 | Captured setting is the unstable combination |
| frac_warn_o | output | 1 | Fractional mode with fine count of 2 or less |

## Verification
The hardest case to reach from the ports is a configuration write that lands strictly inside a long division cycle. Catching a truncated or merged period depends on knowing where the cycle boundary is. The stimulus first synchronises on an observed pulse, waits a known number of cycles, and then changes the ratio. It then measures the current period and the one after it separately. Fractional totals are measured over 64 pulses that start on a pulse edge. Because the accumulator starts each window below 64, the expected total is exact whatever phase earlier settings left behind.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  localparam int unsigned AW = 4;
  localparam int unsigned FW = 6;
endpackage

// File: rtl/fbd_decode.sv
module fbd_decode
  import fbd_pkg::*;
#(
  parameter int unsigned NW = 8,
  localparam int unsigned RW = NW + 2
) (
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  logic [FW-1:0] offset_i,
  input  logic          frac_en_i,
  input  logic          ss_en_i,
  output logic [RW-1:0] base_o,
  output logic [FW-1:0] step_o,
  output logic          use_frac_o,
  output logic          err_o,
  output logic          warn_o
);
  always_comb begin
    base_o     = (RW'(n_i) << 1) + RW'(a_i) + RW'(1);
    use_frac_o = frac_en_i;
    step_o     = frac_en_i ? offset_i : '0;
    err_o      = ss_en_i && !frac_en_i && (offset_i == '0);
    warn_o     = frac_en_i && (a_i <= AW'(2));
  end
endmodule

// File: rtl/fbd_accum.sv
module fbd_accum
  import fbd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          use_i,
  input  logic [FW-1:0] inc_i,
  output logic          carry_o,
  output logic [FW-1:0] acc_o
);
  logic [FW-1:0] acc_q;
  logic [FW:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, inc_i};
  assign carry_o = use_i & sum[FW];
  assign acc_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= use_i ? sum[FW-1:0] : '0;
  end
endmodule

// File: rtl/fbd_count.sv
module fbd_count #(
  parameter int unsigned RW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] load_val_i,
  output logic          bnd_o,
  output logic          pulse_o
);
  logic [RW-1:0] cnt_q;
  logic          run_q;
  logic          zero;

  assign zero    = (cnt_q == '0);
  assign bnd_o   = !run_q || zero;
  assign pulse_o = run_q && zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      cnt_q <= bnd_o ? load_val_i : cnt_q - RW'(1);
    end
  end
endmodule

// File: rtl/frac_fb_div.sv
module frac_fb_div
  import fbd_pkg::*;
#(
  parameter int unsigned NW = 8,
  localparam int unsigned RW = NW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  logic [FW-1:0] offset_i,
  input  logic          frac_en_i,
  input  logic          ss_en_i,
  output logic          div_o,
  output logic          cfg_err_o,
  output logic          frac_warn_o
);
  logic [RW-1:0] base;
  logic [FW-1:0] step;
  logic          use_frac, err, warn, carry, bnd;
  logic [FW-1:0] acc;
  logic [RW-1:0] load_val;
  logic          err_q, warn_q;

  fbd_decode #(.NW(NW)) u_dec (
    .n_i(n_i), .a_i(a_i), .offset_i(offset_i), .frac_en_i(frac_en_i),
    .ss_en_i(ss_en_i), .base_o(base), .step_o(step), .use_frac_o(use_frac),
    .err_o(err), .warn_o(warn)
  );

  fbd_accum u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(bnd), .use_i(use_frac),
    .inc_i(step), .carry_o(carry), .acc_o(acc)
  );

  // period = base + carry, counter runs load_val .. 0
  assign load_val = base + RW'(carry) - RW'(1);

  fbd_count #(.RW(RW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_val_i(load_val),
    .bnd_o(bnd), .pulse_o(div_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      warn_q <= 1'b0;
    end else if (bnd) begin
      err_q  <= err;
      warn_q <= warn;
    end
  end

  assign cfg_err_o   = err_q;
  assign frac_warn_o = warn_q;
endmodule

// File: rtl/fbd_chk.sv
module fbd_chk
  import fbd_pkg::*;
#(
  parameter int unsigned NW = 8,
  localparam int unsigned RW = NW + 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NW-1:0] n_i,
  input logic [AW-1:0] a_i,
  input logic [FW-1:0] offset_i,
  input logic          frac_en_i,
  input logic          ss_en_i,
  input logic          div_o,
  input logic          cfg_err_o,
  input logic          frac_warn_o,
  input logic [FW-1:0] acc
);
  logic          started;
  logic [RW:0]   per;
  logic [RW:0]   exp_ratio;
  logic          exp_frac;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started   <= 1'b0;
      per       <= '0;
      exp_ratio <= '0;
      exp_frac  <= 1'b0;
    end else begin
      started <= 1'b1;
      if (div_o)              per <= (RW+1)'(1);
      else if (per != '1)     per <= per + (RW+1)'(1);
      if (!started || div_o) begin
        exp_ratio <= (RW+1)'(2 * n_i) + (RW+1)'(a_i) + (RW+1)'(1);
        exp_frac  <= frac_en_i;
      end
    end
  end

  AST_PERIOD_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> (per == exp_ratio) || (exp_frac && per == exp_ratio + (RW+1)'(1))); // R2

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !div_o) |=> $stable({cfg_err_o, frac_warn_o})); // R7

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o && ss_en_i && !frac_en_i && offset_i == '0) |=> cfg_err_o); // R5

  AST_WARN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o && frac_en_i && a_i <= AW'(2)) |=> frac_warn_o); // R6

  AST_ACC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o && !frac_en_i) |=> (acc == '0)); // R1
endmodule

bind frac_fb_div fbd_chk #(.NW(NW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .n_i(n_i), .a_i(a_i), .offset_i(offset_i),
  .frac_en_i(frac_en_i), .ss_en_i(ss_en_i), .div_o(div_o),
  .cfg_err_o(cfg_err_o), .frac_warn_o(frac_warn_o), .acc(acc)
);

// File: tb/frac_fb_div_tb.sv
`timescale 1ns/1ps
module frac_fb_div_tb;
  localparam int NW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NW-1:0] n_i = '0;
  logic [3:0]    a_i = '0;
  logic [5:0]    offset_i = '0;
  logic          frac_en_i = 1'b0;
  logic          ss_en_i = 1'b0;
  logic          div_o, cfg_err_o, frac_warn_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  frac_fb_div #(.NW(NW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .n_i(n_i), .a_i(a_i), .offset_i(offset_i),
    .frac_en_i(frac_en_i), .ss_en_i(ss_en_i), .div_o(div_o),
    .cfg_err_o(cfg_err_o), .frac_warn_o(frac_warn_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int n, input int a, input int off, input bit fe, input bit se);
    @(negedge clk_i);
    n_i = NW'(n); a_i = 4'(a); offset_i = 6'(off); frac_en_i = fe; ss_en_i = se;
  endtask

  task automatic wait_pulse();
    do @(negedge clk_i); while (!div_o);
  endtask

  // cycles over 64 periods starting on a pulse; dbl counts back-to-back highs
  task automatic measure64(output int cyc, output int dbl);
    int p = 0;
    bit prev = 1'b1;
    cyc = 0; dbl = 0;
    wait_pulse();
    while (p < 64) begin
      @(negedge clk_i);
      cyc++;
      if (div_o) begin
        p++;
        if (prev) dbl++;
      end
      prev = div_o;
    end
  endtask

  task automatic t_reset();
    int c = 0;
    n_i = NW'(3); a_i = 4'd1; offset_i = 6'd20; frac_en_i = 1'b0; ss_en_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R9 div in reset", int'(div_o), 0);
    check("R9 err in reset", int'(cfg_err_o), 0);
    check("R9 warn in reset", int'(frac_warn_o), 0);
    rst_ni = 1'b1;
    do begin @(negedge clk_i); c++; end while (!div_o && c < 100);
    check("R9 first pulse cycle", c, 8);
  endtask

  task automatic t_integer();
    int cyc, dbl;
    set_cfg(3, 1, 20, 1'b0, 1'b0);
    measure64(cyc, dbl);
    check("R1 integer ratio 8 offset ignored", cyc, 512);
    check("R8 single-cycle pulse", dbl, 0);
    check("R5 no error legal", int'(cfg_err_o), 0);
    check("R6 no warn integer", int'(frac_warn_o), 0);
  endtask

  task automatic t_example();
    int cyc, dbl;
    set_cfg(15, 2, 48, 1'b1, 1'b0);
    measure64(cyc, dbl);
    check("R3 ratio 33.75 total", cyc, 2160);
    check("R6 warn a=2", int'(frac_warn_o), 1);
    check("R8 single-cycle pulse frac", dbl, 0);
  endtask

  task automatic t_frac_ss();
    int cyc, dbl;
    set_cfg(10, 5, 1, 1'b1, 1'b0);
    measure64(cyc, dbl);
    check("R2 offset 1 total", cyc, 1665);
    check("R6 no warn a=5", int'(frac_warn_o), 0);
    set_cfg(10, 5, 1, 1'b1, 1'b1);
    measure64(cyc, dbl);
    check("R4 ss ignored in frac mode", cyc, 1665);
    check("R5 no error in frac mode", int'(cfg_err_o), 0);
    set_cfg(255, 15, 63, 1'b1, 1'b1);
    measure64(cyc, dbl);
    check("R2 max ratio offset 63", cyc, 64 * 526 + 63);
  endtask

  task automatic t_error();
    int cyc, dbl;
    set_cfg(4, 3, 0, 1'b0, 1'b1);
    measure64(cyc, dbl);
    check("R5 illegal combo integer ratio", cyc, 768);
    check("R5 error flag set", int'(cfg_err_o), 1);
    set_cfg(4, 3, 5, 1'b0, 1'b1);
    measure64(cyc, dbl);
    check("R5 nonzero offset legal", int'(cfg_err_o), 0);
    check("R1 offset ignored spread on", cyc, 768);
  endtask

  task automatic t_midcycle();
    int c;
    set_cfg(9, 1, 0, 1'b0, 1'b0);
    wait_pulse();
    wait_pulse();
    repeat (5) @(negedge clk_i);
    n_i = NW'(2); a_i = 4'd0;
    c = 5;
    do begin @(negedge clk_i); c++; end while (!div_o && c < 100);
    check("R7 mid-cycle write keeps period", c, 20);
    c = 0;
    do begin @(negedge clk_i); c++; end while (!div_o && c < 100);
    check("R7 new ratio next period", c, 5);
  endtask

  task automatic t_unity();
    int cyc, dbl;
    set_cfg(0, 0, 0, 1'b0, 1'b0);
    measure64(cyc, dbl);
    check("R8 ratio 1 total", cyc, 64);
    check("R8 ratio 1 high every cycle", dbl, 64);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_integer();
    t_example();
    t_frac_ss();
    t_error();
    t_midcycle();
    t_unity();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule